// File: doc/BRIEF.md
# LED Bank Controller

This block is a bus slave that drives a bank of LED outputs from registers a processor writes. A host reaches it through a small memory-mapped port: a 4-bit word offset, separate read and write strobes, and 32-bit read and write data. The system interconnect removes the base address before the offset reaches the block. A plain output vector carries the LED levels to the pins.

Three registers control the outputs. The control register at offset 0 has a master enable (bit 0) and a blink enable (bit 1). The pattern register at offset 1 holds one bit per LED. The period register at offset 2 sets the blink half-period in clock cycles. When blinking is on and the period is not zero, the lit pattern and all-dark alternate without any help from software. Every register can be read back.

The port has no back-pressure. There is no valid/ready pair. A strobe is taken in the cycle it is high, and read data comes back after a fixed delay.

Top module: `led_bank_ctrl`

## Requirements
- R1: After reset, `led_out` is all zero and reads of offsets 0, 1 and 2 return zero.
- R2: A write to offset 1 stores the low `N_LED` bits of the write data in the pattern register. While bit 0 of the control register is 1, pattern bit n drives `led_out[n]`.
- R3: A register changes only on a rising edge where `bus_wr` is 1 and `bus_addr` equals that register's offset. A write to an unmapped offset, or a cycle with `bus_wr` at 0, leaves every register and `led_out` unchanged.
- R4: While control bit 0 is 0, `led_out` is all zero. The pattern register keeps its value and can still be written and read.
- R5: Read data is registered. When `bus_rd` is 1 at an edge, `bus_rdata` shows the addressed register in the following cycle, with unused upper bits at zero. In every other cycle `bus_rdata` is zero. Unmapped offsets read as zero.
- R6: The control register stores only write-data bits 1:0. Its read value has all other bits at zero.
- R7: When control bits 1 and 0 are both 1 and the period P (offset 2) is not zero, `led_out` shows the pattern for P cycles and then is dark for P cycles, and this repeats. The first lit span starts at the edge that captures the period write.
- R8: When control bit 1 is 0, or P is 0, `led_out` holds the pattern steadily.
- R9: A write to offset 2 restarts the blink timer in the lit phase. This holds even when the write falls on the edge where the phase would otherwise toggle.
- R10: With `N_LED` set to 6, all six outputs follow the pattern, and the pattern reads back as 6 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Local word offset |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| led_out | output | N_LED | LED drive levels |

## Verification
The blink timer's phase toggle and a software rewrite of the period can land on the same clock edge.

The bench lets a period of 3 run for more than one span. It then schedules a period write for exactly the edge where the timer would next go dark. The restart must win: the outputs must stay lit for three full cycles after that edge.

A read and a write to the same offset in one cycle is also possible. The register-file logic orders these so that the read returns the old value.

// File: rtl/led_bank_pkg.sv
package led_bank_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_PATTERN = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_PERIOD  = 4'd2;

  typedef struct packed {
    logic blink;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/led_regfile.sv
module led_regfile
  import led_bank_pkg::*;
#(
  parameter int N_LED    = 4,
  parameter int PERIOD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output ctrl_t             ctrl,
  output logic [N_LED-1:0]  pattern,
  output logic [PERIOD_W-1:0] period,
  output logic              period_wr
);
  logic hit_ctrl, hit_pat, hit_per;
  logic [BUS_W-1:0] rd_mux;

  assign hit_ctrl  = wr && (addr == OFS_CTRL);
  assign hit_pat   = wr && (addr == OFS_PATTERN);
  assign hit_per   = wr && (addr == OFS_PERIOD);
  assign period_wr = hit_per;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      pattern <= '0;
      period  <= '0;
    end else begin
      if (hit_ctrl) ctrl <= ctrl_t'(wdata[1:0]);
      if (hit_pat)  pattern <= wdata[N_LED-1:0];
      if (hit_per)  period <= wdata[PERIOD_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CTRL:    rd_mux[1:0] = ctrl;
      OFS_PATTERN: rd_mux[N_LED-1:0] = pattern;
      OFS_PERIOD:  rd_mux[PERIOD_W-1:0] = period;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
    else         rdata <= '0;
  end

  p_pattern_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_PATTERN) |=> pattern == $past(wdata[N_LED-1:0]));
  p_no_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(pattern) && $stable(ctrl) && $stable(period)));
  p_idle_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0);
  p_ctrl_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == OFS_CTRL) |=> rdata[BUS_W-1:2] == '0);
endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
  parameter int PERIOD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                blink_on,
  input  logic [PERIOD_W-1:0] period,
  input  logic                restart,
  output logic                dark
);
  logic [PERIOD_W-1:0] cnt;
  logic active;
  logic at_end;

  assign active = blink_on && (period != '0);
  assign at_end = (cnt == period - PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dark <= 1'b0;
    end else if (restart || !active) begin
      cnt  <= '0;
      dark <= 1'b0;
    end else if (at_end) begin
      cnt  <= '0;
      dark <= ~dark;
    end else begin
      cnt <= cnt + PERIOD_W'(1);
    end
  end

  p_restart_lit_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !dark));
  p_idle_steady_r8: assert property (@(posedge clk) disable iff (rst)
    !active |=> !dark);
  p_toggle_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    (active && !restart && !at_end) |=> $stable(dark));
endmodule

// File: rtl/led_out_gate.sv
module led_out_gate #(
  parameter int N_LED = 4
) (
  input  logic             en,
  input  logic             dark,
  input  logic [N_LED-1:0] pattern,
  output logic [N_LED-1:0] led
);
  for (genvar i = 0; i < N_LED; i++) begin : g_bit
    assign led[i] = en & ~dark & pattern[i];
  end
endmodule

// File: rtl/led_bank_ctrl.sv
module led_bank_ctrl
  import led_bank_pkg::*;
#(
  parameter int N_LED    = 4,
  parameter int PERIOD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       bus_addr,
  input  logic             bus_rd,
  output logic [31:0]      bus_rdata,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [N_LED-1:0] led_out
);
  ctrl_t ctrl;
  logic [N_LED-1:0] pattern;
  logic [PERIOD_W-1:0] period;
  logic period_wr;
  logic dark;

  led_regfile #(.N_LED(N_LED), .PERIOD_W(PERIOD_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ctrl(ctrl), .pattern(pattern),
    .period(period), .period_wr(period_wr)
  );

  led_blink_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst(rst), .blink_on(ctrl.blink), .period(period),
    .restart(period_wr), .dark(dark)
  );

  led_out_gate #(.N_LED(N_LED)) u_gate (
    .en(ctrl.en), .dark(dark), .pattern(pattern), .led(led_out)
  );

  p_disable_dark_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CTRL && !bus_wdata[0]) |=> led_out == '0);
  p_reset_dark_r1: assert property (@(posedge clk)
    $past(rst) |-> led_out == '0);
endmodule

// File: tb/sim_led_bank_ctrl.sv
module sim_led_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 8;
  // row: {addr[3:0], wdata[31:0], expected readback[31:0], expected led[3:0]}
  localparam logic [71:0] ROWS [NROW] = '{
    {4'd1, 32'hFFFF_FFF5, 32'h0000_0005, 4'h0},  // R2 truncation, R4 disabled
    {4'd0, 32'hFFFF_FFFD, 32'h0000_0001, 4'h5},  // R6 ctrl bits, R2 enabled
    {4'd1, 32'h0000_000A, 32'h0000_000A, 4'hA},  // R2
    {4'd7, 32'h1234_5678, 32'h0000_0000, 4'hA},  // R3 / R5 unmapped
    {4'd2, 32'h0000_0000, 32'h0000_0000, 4'hA},  // R8 period zero
    {4'd0, 32'h0000_0000, 32'h0000_0000, 4'h0},  // R4 disable
    {4'd1, 32'h0000_0003, 32'h0000_0003, 4'h0},  // R4 write while off
    {4'd0, 32'h0000_0001, 32'h0000_0001, 4'h3}   // R4 pattern kept
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [3:0] led0;
  logic [5:0] led1;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_bank_ctrl u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_rdata(rdata0), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .led_out(led0));
  led_bank_ctrl #(.N_LED(6)) u1 (.clk(clk), .rst(rst), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_rdata(rdata1), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .led_out(led1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = rdata0;
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 led", 32'(led0), 32'h0);
    for (int a = 0; a < 3; a++) begin
      do_read(4'(a), rv);
      check("R1 read", rv, 32'h0);
    end
    @(negedge clk);
    check("R5 idle rdata", rdata0, 32'h0);

    for (int i = 0; i < NROW; i++) begin
      do_write(ROWS[i][71:68], ROWS[i][67:36]);
      do_read(ROWS[i][71:68], rv);
      check("R2/R3/R4/R5/R6 readback", rv, ROWS[i][35:4]);
      check("R2/R3/R4 led", 32'(led0), 32'(ROWS[i][3:0]));
    end

    // R3: strobe low with data on the bus
    bus_addr = 4'd1; bus_wdata = 32'hF; @(negedge clk); bus_wdata = '0;
    do_read(4'd1, rv);
    check("R3 no strobe", rv, 32'h3);

    // R5: read and write same cycle returns old contents
    bus_addr = 4'd1; bus_wdata = 32'hA; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R5 read old value", rdata0, 32'h3);
    check("R2 new pattern", 32'(led0), 32'hA);

    // R8: blink enabled, period zero -> steady
    do_write(4'd0, 32'h3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 steady", 32'(led0), 32'hA);
    end

    // R7: period 3
    do_write(4'd2, 32'd3);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R7 blink", 32'(led0), ((k / 3) % 2 == 0) ? 32'hA : 32'h0);
    end
    // R9: rewrite on the would-be toggle edge
    do_write(4'd2, 32'd3);
    check("R9 restart", 32'(led0), 32'hA);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check("R9 restart", 32'(led0), (k < 3) ? 32'hA : 32'h0);
    end
    do_read(4'd2, rv);
    check("R5 period read", rv, 32'd3);

    // R8: blink bit cleared
    do_write(4'd0, 32'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 blink off", 32'(led0), 32'hA);
    end

    // R10: six-LED instance
    do_write(4'd1, 32'hFFFF_FFFF);
    check("R10 led6", 32'(led1), 32'h3F);
    check("R2 led4", 32'(led0), 32'hF);
    bus_addr = 4'd1; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 read6", rdata1, 32'h3F);

    // R1: reset clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 led after reset", 32'(led0), 32'h0);
    do_read(4'd1, rv);
    check("R1 pattern after reset", rv, 32'h0);

    finish_run();
  end
endmodule